// File: doc/BRIEF.md
# Universal Latched/Registered Bus Transceiver

This block moves data in both directions between an A port and a B port. Each port is 18 bits wide by default. Each direction has its own storage element, and that element works in one of three ways. With the latch enable high it is transparent, so the far port follows the near port's input in the same cycle. With the latch enable low it holds its value. It captures new data when a rising edge of its device clock is seen while the active-low clock enable is asserted. An active-low output enable decides whether the direction drives its far port.

All controls are sampled by one system clock. A device-clock rising edge is a sample of 1 that follows a sample of 0. Each port is split into a data-in bus, a per-bit drive mask that marks which input bits are actually driven, a data-out bus and a drive flag. The drive mask stands in for a released (high-impedance) input. A bus-hold register per bit then supplies the last driven value in place of the floating bit.

Top module: `ubx_xcvr`

## Requirements
- R1: With `ab_le` high, `b_dout` equals the effective A input (driven bits from `a_din`, undriven bits from bus hold) in the same cycle, with no system clock edge in between.
- R2: With `ab_le` low and no capture taking place, `b_dout` keeps its value from cycle to cycle while `a_din` changes.
- R3: With `ab_le` low and `ab_dclk_en_n` low, a system edge at which `ab_dclk` is sampled 1 after being sampled 0 at the previous edge stores the effective A input. The stored value appears on `b_dout` after that edge. A steady high `ab_dclk` captures nothing further.
- R4: With `ab_dclk_en_n` high, rising edges of `ab_dclk` are ignored and `b_dout` keeps its value.
- R5: `b_oe` is 1 exactly when `ab_oe_n` was 0 at the previous system edge. The flag lags the input by one cycle.
- R6: The B-to-A direction obeys R1 to R5 with `ba_le`, `ba_dclk`, `ba_dclk_en_n`, `ba_oe_n`, the effective B input, `a_dout` and `a_oe`.
- R7: An input bit whose drive-mask bit is 0 takes the value that bit last had when driven, or 0 if it has not been driven since reset. Both transparent and captured data use this held value.
- R8: When a latch enable falls, the output keeps the value passed through at the last system edge at which the latch enable was high, whatever the device clock level.
- R9: Synchronous active-low `rst_n` clears both stored words and both bus-hold words, and forces `a_oe` and `b_oe` to 0.
- R10: A device clock that is already high when reset is released is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_din | input | DATA_W | A port input data |
| a_drive | input | DATA_W | Per-bit mask, 1 = A input bit driven |
| a_dout | output | DATA_W | Data presented on the A port (B-to-A path) |
| a_oe | output | 1 | A port drive flag |
| b_din | input | DATA_W | B port input data |
| b_drive | input | DATA_W | Per-bit mask, 1 = B input bit driven |
| b_dout | output | DATA_W | Data presented on the B port (A-to-B path) |
| b_oe | output | 1 | B port drive flag |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B latch enable, active high |
| ab_dclk | input | 1 | A-to-B device clock |
| ab_dclk_en_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A latch enable, active high |
| ba_dclk | input | 1 | B-to-A device clock |
| ba_dclk_en_n | input | 1 | B-to-A clock enable, active low |

## Verification
In transparent mode a data output reflects its input with no edge in between. A capture, a hold-register update and a change of the drive flag all show up just after the first system edge that samples the new inputs. Inputs change only at falling edges. At each falling edge the bench's model works out the post-edge state and queues the expected outputs. The monitor compares them 3 ns after the next rising edge, so every result is read one register stage after the stimulus that caused it.

// File: rtl/ubx_pkg.sv
package ubx_pkg;

  typedef enum logic [1:0] {
    LANE_KEEP    = 2'd0,
    LANE_PASS    = 2'd1,
    LANE_CAPTURE = 2'd2
  } lane_mode_e;

  // Rising edge seen between two consecutive samples.
  function automatic logic rise_seen(input logic now_s, input logic prev_s);
    return now_s & ~prev_s;
  endfunction

  // Mode for one direction, highest precedence first.
  function automatic lane_mode_e pick_mode(input logic le,
                                           input logic clk_en_n,
                                           input logic rise);
    if (le)
      return LANE_PASS;
    else if (!clk_en_n && rise)
      return LANE_CAPTURE;
    else
      return LANE_KEEP;
  endfunction

  // Merge driven bits with held bits.
  function automatic logic merge_bit(input logic drv, input logic val,
                                     input logic held);
    return drv ? val : held;
  endfunction

endpackage

// File: rtl/ubx_bus_hold.sv
module ubx_bus_hold #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] pin_val,
  input  logic [DATA_W-1:0] pin_drv,
  output logic [DATA_W-1:0] eff,
  output logic [DATA_W-1:0] held
);
  import ubx_pkg::*;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic hq;
    assign eff[i]  = merge_bit(pin_drv[i], pin_val[i], hq);
    assign held[i] = hq;
    always_ff @(posedge clk) begin
      if (!rst_n) hq <= 1'b0;
      else        hq <= eff[i];
    end
  end

endmodule

// File: rtl/ubx_lane.sv
module ubx_lane #(
  parameter int DATA_W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   din_eff,
  input  logic                le,
  input  logic                dclk,
  input  logic                dclk_en_n,
  input  logic                oe_n,
  output logic [DATA_W-1:0]   dout,
  output logic                drive,
  output ubx_pkg::lane_mode_e mode,
  output logic                rise
);
  import ubx_pkg::*;

  logic              dclk_q;
  logic [DATA_W-1:0] store_q;
  logic              drive_q;

  assign rise = rise_seen(dclk, dclk_q);
  assign mode = pick_mode(le, dclk_en_n, rise);

  // Reset value 1 so a clock already high is not an edge.
  always_ff @(posedge clk) begin
    if (!rst_n) dclk_q <= 1'b1;
    else        dclk_q <= dclk;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_q <= '0;
    end else begin
      unique case (mode)
        LANE_PASS, LANE_CAPTURE: store_q <= din_eff;
        default:                 store_q <= store_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) drive_q <= 1'b0;
    else        drive_q <= ~oe_n;
  end

  assign dout  = (mode == LANE_PASS) ? din_eff : store_q;
  assign drive = drive_q;

endmodule

// File: rtl/ubx_xcvr.sv
module ubx_xcvr #(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_din,
  input  logic [DATA_W-1:0] a_drive,
  output logic [DATA_W-1:0] a_dout,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_din,
  input  logic [DATA_W-1:0] b_drive,
  output logic [DATA_W-1:0] b_dout,
  output logic              b_oe,
  input  logic              ab_oe_n,
  input  logic              ab_le,
  input  logic              ab_dclk,
  input  logic              ab_dclk_en_n,
  input  logic              ba_oe_n,
  input  logic              ba_le,
  input  logic              ba_dclk,
  input  logic              ba_dclk_en_n
);
  import ubx_pkg::*;

  // Named internal events for the checker.
  logic [DATA_W-1:0] a_eff, b_eff, a_held, b_held;
  lane_mode_e        ab_mode, ba_mode;
  logic              ab_rise, ba_rise;

  ubx_bus_hold #(.DATA_W(DATA_W)) u_hold_a (
    .clk(clk), .rst_n(rst_n), .pin_val(a_din), .pin_drv(a_drive),
    .eff(a_eff), .held(a_held)
  );

  ubx_bus_hold #(.DATA_W(DATA_W)) u_hold_b (
    .clk(clk), .rst_n(rst_n), .pin_val(b_din), .pin_drv(b_drive),
    .eff(b_eff), .held(b_held)
  );

  ubx_lane #(.DATA_W(DATA_W)) u_lane_ab (
    .clk(clk), .rst_n(rst_n), .din_eff(a_eff), .le(ab_le),
    .dclk(ab_dclk), .dclk_en_n(ab_dclk_en_n), .oe_n(ab_oe_n),
    .dout(b_dout), .drive(b_oe), .mode(ab_mode), .rise(ab_rise)
  );

  ubx_lane #(.DATA_W(DATA_W)) u_lane_ba (
    .clk(clk), .rst_n(rst_n), .din_eff(b_eff), .le(ba_le),
    .dclk(ba_dclk), .dclk_en_n(ba_dclk_en_n), .oe_n(ba_oe_n),
    .dout(a_dout), .drive(a_oe), .mode(ba_mode), .rise(ba_rise)
  );

endmodule

// File: rtl/ubx_xcvr_chk.sv
module ubx_xcvr_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] a_din,
  input logic [DATA_W-1:0] a_drive,
  input logic [DATA_W-1:0] a_dout,
  input logic              a_oe,
  input logic [DATA_W-1:0] b_din,
  input logic [DATA_W-1:0] b_drive,
  input logic [DATA_W-1:0] b_dout,
  input logic              b_oe,
  input logic              ab_oe_n,
  input logic              ab_le,
  input logic              ab_dclk_en_n,
  input logic              ba_oe_n,
  input logic              ba_le,
  input logic              ba_dclk_en_n,
  input logic [DATA_W-1:0] a_eff,
  input logic [DATA_W-1:0] b_eff,
  input logic [DATA_W-1:0] a_held,
  input logic              ab_rise,
  input logic              ba_rise
);

  AST_AB_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_le && a_drive == '1) |-> (b_dout == a_din)); // R1

  AST_AB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && (ab_dclk_en_n || !ab_rise)) |=> (ab_le || $stable(b_dout))); // R2

  AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !ab_dclk_en_n && ab_rise) |=> (ab_le || b_dout == $past(a_eff))); // R3

  AST_AB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && ab_dclk_en_n) |=> (ab_le || $stable(b_dout))); // R4

  AST_AB_OE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (b_oe == !$past(ab_oe_n))); // R5

  AST_BA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && !ba_dclk_en_n && ba_rise) |=> (ba_le || a_dout == $past(b_eff))); // R6

  AST_BA_OE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (a_oe == !$past(ba_oe_n))); // R6

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (a_drive == '0) |=> (a_held == $past(a_held))); // R7

  AST_LE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_le && ab_dclk_en_n) |=> (ab_le || b_dout == $past(a_eff))); // R8

endmodule

bind ubx_xcvr ubx_xcvr_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_ubx_xcvr.sv
module test_ubx_xcvr;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_din = '0, a_drive = '1, b_din = '0, b_drive = '1;
  logic [W-1:0] a_dout, b_dout;
  logic a_oe, b_oe;
  logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_dclk = 1'b1, ab_dclk_en_n = 1'b0;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_dclk = 1'b0, ba_dclk_en_n = 1'b1;

  always #5 clk = ~clk;

  ubx_xcvr #(.DATA_W(W)) i_ubx_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_din(a_din), .a_drive(a_drive), .a_dout(a_dout), .a_oe(a_oe),
    .b_din(b_din), .b_drive(b_drive), .b_dout(b_dout), .b_oe(b_oe),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_dclk(ab_dclk), .ab_dclk_en_n(ab_dclk_en_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_dclk(ba_dclk), .ba_dclk_en_n(ba_dclk_en_n)
  );

  typedef struct {
    string        req;
    int           sel;
    logic [W-1:0] val;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference model state (post-reset values).
  logic [W-1:0] m_hold_a = '0, m_hold_b = '0, m_st_ab = '0, m_st_ba = '0;
  logic m_clk_ab = 1'b1, m_clk_ba = 1'b1, m_oe_b = 1'b0, m_oe_a = 1'b0;

  // Driver: called at a falling edge after inputs are set.
  task automatic go(input string req);
    logic [W-1:0] ea, eb;
    ea = (a_drive & a_din) | (~a_drive & m_hold_a);
    eb = (b_drive & b_din) | (~b_drive & m_hold_b);
    m_hold_a = ea;
    m_hold_b = eb;
    if (ab_le || (!ab_dclk_en_n && ab_dclk && !m_clk_ab)) m_st_ab = ea;
    if (ba_le || (!ba_dclk_en_n && ba_dclk && !m_clk_ba)) m_st_ba = eb;
    m_clk_ab = ab_dclk;
    m_clk_ba = ba_dclk;
    m_oe_b = !ab_oe_n;
    m_oe_a = !ba_oe_n;
    exp_q.push_back('{req, 0, ab_le ? ea : m_st_ab});
    exp_q.push_back('{req, 1, ba_le ? eb : m_st_ba});
    exp_q.push_back('{req, 2, {{(W-1){1'b0}}, m_oe_b}});
    exp_q.push_back('{req, 3, {{(W-1){1'b0}}, m_oe_a}});
    @(negedge clk);
  endtask

  // Monitor: compares queued items 3 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (exp_q.size() > 0) begin
        exp_t it;
        logic [W-1:0] act;
        it = exp_q.pop_front();
        case (it.sel)
          0: act = b_dout;
          1: act = a_dout;
          2: act = {{(W-1){1'b0}}, b_oe};
          default: act = {{(W-1){1'b0}}, a_oe};
        endcase
        checks++;
        if (act !== it.val) begin
          failures++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.val);
        end
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    a_din = 18'h2AAAA;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    go("R9");                        // cleared state, clock high at release
    go("R10");                       // steady high clock: no capture
    ab_le = 1'b1;
    a_din = 18'h12345; go("R1");
    a_din = 18'h3FFFF; go("R1");
    a_din = 18'h00000; go("R1");
    a_din = 18'h0F0F0; go("R1");
    ab_le = 1'b0; a_din = 18'h11111; go("R8");
    a_din = 18'h22222; go("R2");
    a_din = 18'h01234; go("R2");
    ab_dclk = 1'b0; go("R3");
    ab_dclk = 1'b1; a_din = 18'h33333; go("R3");
    a_din = 18'h04444; go("R3");
    ab_dclk_en_n = 1'b1; ab_dclk = 1'b0; go("R4");
    ab_dclk = 1'b1; a_din = 18'h05555; go("R4");
    ab_oe_n = 1'b0; go("R5");
    go("R5");
    ab_oe_n = 1'b1; go("R5");
    ba_le = 1'b1; b_din = 18'h2BCDE; go("R6");
    ba_le = 1'b0; b_din = 18'h00001; go("R6");
    ba_dclk_en_n = 1'b0; ba_dclk = 1'b0; go("R6");
    ba_dclk = 1'b1; b_din = 18'h01357; go("R6");
    ba_oe_n = 1'b0; go("R6");
    ab_le = 1'b1; a_din = 18'h3C3C3; a_drive = '1; go("R7");
    a_drive = '0; a_din = '0; go("R7");
    a_drive = 18'h000FF; a_din = 18'h00055; go("R7");
    ba_le = 1'b1; b_drive = '0; b_din = 18'h3FFFF; go("R7");
    ab_le = 1'b0; a_drive = '1; go("R8");
    @(posedge clk);
    #4;
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule